// File: doc/BRIEF.md
# Translation Unit Control and Fault Registers

This block is the software-visible register file of one address-translation unit that sits between a video-codec bus master and memory. A 32-bit register bus writes and reads it. It holds the translation enable, the base pointer of the top-level table array, the out-of-bound handling switch and the exception-reporting enable, and it drives them as levels into the translation logic.

Software turns on the unit in a set order. It first checks whether the enable bit already reads 1, and if so it skips the sequence. Otherwise it loads the base pointer, the configuration and the exception enable, and it sets the enable bit last. To invalidate every cached translation, software writes bit 4 of the flush register to 1 and then to 0. The block turns the rising edge of that bit into a single-cycle pulse. The table walker reports faults with a cause code and an address. The block records them in a status register, keeps the address of the first fault, and raises a level interrupt when exception reporting is on. A read of the same offset that enables exceptions returns that address.

Top module: `xlat_ctrl_regs`

## Requirements
- R1: After reset every output is 0: enable, base pointer, out-of-bound enable, flush pulse, interrupt, and read data at every offset.
- R2: Control register at offset 0x388. A write stores bit 0 as the translation enable, so writing 0 disables the unit. A read returns the bit in position 0 and zeros above it.
- R3: Base register at offset 0x38C. It stores all 32 bits, drives them on the base output and reads them back unchanged.
- R4: Configuration register at offset 0x1AC. Only bit 28 is stored. It drives the out-of-bound enable output. A read returns bit 28 and zeros in every other bit.
- R5: Offset 0x380 has two meanings. A write stores bit 0 as the exception enable, which is never read back. A read returns the captured fault address.
- R6: Status register at offset 0x384. When the walker reports a fault with a nonzero 3-bit cause, the cause is ORed into status bits 2:0. A write keeps only the status bits that are written as 1, so writing 0 clears the register. A read returns the status in bits 2:0 and zeros above it.
- R7: The fault address is captured only when no cause bit remains pending after that cycle's status write. A later fault leaves the first address in place until software clears the status.
- R8: The interrupt output is 1 exactly when the exception enable is 1 and at least one status bit is set.
- R9: Flush register at offset 0x184. Bit 4 is stored and read back in position 4. Writing it 1 while it holds 0 gives a flush pulse of exactly one cycle, in the cycle after the write. Writing 1 while it already holds 1 gives no pulse.
- R10: Reads at any other offset return 0. Writes to any other offset change no register and no output.
- R11: If a status write and a new fault fall in the same cycle, the new cause survives the clear. The new address is captured when the write leaves nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte offset of the register access |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| flt_valid | input | 1 | Walker reports a fault this cycle |
| flt_cause | input | CAUSE_W | Fault cause bits |
| flt_addr | input | DATA_W | Address of the faulting access |
| xlat_en | output | 1 | Translation enable |
| tbl_base | output | DATA_W | Table-array base pointer |
| oob_en | output | 1 | Out-of-bound handling enable |
| flush_pulse | output | 1 | One-cycle invalidate-all request |
| irq | output | 1 | Level fault interrupt |

## Verification
A walker fault report and a software write to the status register can land in the same clock cycle. That pairing decides both the surviving cause bits and whether the address is captured. The bench provokes it with directed cases: a full clear with a new fault, and a partial clear that leaves an older bit pending with a new fault. Random traffic also hits it often, because faults arrive with random causes while the bus writes random values to the status offset. Each outcome is judged against a reference model that applies the clear mask to the old status before ORing in the new cause. The same model decides whether the address is captured from the pending state left after the mask.

// File: rtl/xlat_ctrl_regs.sv
module xlat_ctrl_regs #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int CAUSE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              flt_valid,
  input  logic [CAUSE_W-1:0] flt_cause,
  input  logic [DATA_W-1:0] flt_addr,
  output logic              xlat_en,
  output logic [DATA_W-1:0] tbl_base,
  output logic              oob_en,
  output logic              flush_pulse,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] OFS_FLUSH = ADDR_W'(12'h184);
  localparam logic [ADDR_W-1:0] OFS_CFG   = ADDR_W'(12'h1AC);
  localparam logic [ADDR_W-1:0] OFS_EXC   = ADDR_W'(12'h380);
  localparam logic [ADDR_W-1:0] OFS_STAT  = ADDR_W'(12'h384);
  localparam logic [ADDR_W-1:0] OFS_CTRL  = ADDR_W'(12'h388);
  localparam logic [ADDR_W-1:0] OFS_BASE  = ADDR_W'(12'h38C);
  localparam int FLUSH_BIT = 4;
  localparam int OOB_BIT   = 28;

  logic               exc_en, flush_q;
  logic [CAUSE_W-1:0] stat_q, keep, stat_left, new_cause;
  logic [DATA_W-1:0]  flt_addr_q;

  wire wr_flush = reg_wr && reg_addr == OFS_FLUSH;
  wire wr_cfg   = reg_wr && reg_addr == OFS_CFG;
  wire wr_exc   = reg_wr && reg_addr == OFS_EXC;
  wire wr_stat  = reg_wr && reg_addr == OFS_STAT;
  wire wr_ctrl  = reg_wr && reg_addr == OFS_CTRL;
  wire wr_base  = reg_wr && reg_addr == OFS_BASE;

  assign keep      = wr_stat ? reg_wdata[CAUSE_W-1:0] : '1;
  assign stat_left = stat_q & keep;
  assign new_cause = flt_valid ? flt_cause : '0;
  assign irq       = exc_en && (|stat_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xlat_en     <= 1'b0;
      tbl_base    <= '0;
      oob_en      <= 1'b0;
      exc_en      <= 1'b0;
      flush_q     <= 1'b0;
      flush_pulse <= 1'b0;
      stat_q      <= '0;
      flt_addr_q  <= '0;
    end else begin
      if (wr_ctrl) xlat_en  <= reg_wdata[0];
      if (wr_base) tbl_base <= reg_wdata;
      if (wr_cfg)  oob_en   <= reg_wdata[OOB_BIT];
      if (wr_exc)  exc_en   <= reg_wdata[0];
      if (wr_flush) flush_q <= reg_wdata[FLUSH_BIT];
      flush_pulse <= wr_flush && reg_wdata[FLUSH_BIT] && !flush_q;
      stat_q <= stat_left | new_cause;
      if ((|new_cause) && !(|stat_left)) flt_addr_q <= flt_addr;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      OFS_FLUSH: reg_rdata[FLUSH_BIT]   = flush_q;
      OFS_CFG:   reg_rdata[OOB_BIT]     = oob_en;
      OFS_EXC:   reg_rdata              = flt_addr_q;
      OFS_STAT:  reg_rdata[CAUSE_W-1:0] = stat_q;
      OFS_CTRL:  reg_rdata[0]           = xlat_en;
      OFS_BASE:  reg_rdata              = tbl_base;
      default:   reg_rdata              = '0;
    endcase
  end

  wire wr_undef = reg_wr && !(wr_flush || wr_cfg || wr_exc || wr_stat || wr_ctrl || wr_base);

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctrl |=> xlat_en == $past(reg_wdata[0])); // R2
  AST_BASE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_base |=> tbl_base == $past(reg_wdata)); // R3
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[CAUSE_W-1:0] == '0 && !flt_valid) |=> reg_rdata == '0 || reg_addr != OFS_STAT); // R6
  AST_FIRST_FAULT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ((|stat_q) && !wr_stat) |=> $stable(flt_addr_q)); // R7
  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(flt_valid && (|flt_cause)) || $past(wr_exc)); // R8
  AST_FLUSH_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |=> !flush_pulse); // R9
  AST_FLUSH_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(wr_flush && reg_wdata[FLUSH_BIT])); // R9
  AST_UNDEF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_undef |=> $stable(xlat_en) && $stable(tbl_base) && $stable(oob_en) && !flush_pulse); // R10
endmodule

// File: tb/xlat_ctrl_regs_tb.sv
`timescale 1ns/1ps
module xlat_ctrl_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic flt_valid = 1'b0;
  logic [2:0] flt_cause = '0;
  logic [31:0] flt_addr = '0, tbl_base;
  logic xlat_en, oob_en, flush_pulse, irq;

  always #4 clk = ~clk;

  xlat_ctrl_regs dut_i (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .flt_valid(flt_valid), .flt_cause(flt_cause),
    .flt_addr(flt_addr), .xlat_en(xlat_en), .tbl_base(tbl_base), .oob_en(oob_en),
    .flush_pulse(flush_pulse), .irq(irq));

  int tests = 0, fails = 0;
  logic m_en, m_oob, m_exc, m_fbit, m_pulse;
  logic [31:0] m_base, m_faddr;
  logic [2:0] m_stat;

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic [11:0] a);
    case (a)
      12'h184: return {27'b0, m_fbit, 4'b0};
      12'h1AC: return {3'b0, m_oob, 28'b0};
      12'h380: return m_faddr;
      12'h384: return {29'b0, m_stat};
      12'h388: return {31'b0, m_en};
      12'h38C: return m_base;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string rd_tag(logic [11:0] a);
    case (a)
      12'h184: return "R9";
      12'h1AC: return "R4";
      12'h380: return "R5";
      12'h384: return "R6";
      12'h388: return "R2";
      12'h38C: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic check_all();
    chk("R2", "xlat_en", {31'b0, xlat_en}, {31'b0, m_en});
    chk("R3", "tbl_base", tbl_base, m_base);
    chk("R4", "oob_en", {31'b0, oob_en}, {31'b0, m_oob});
    chk("R8", "irq", {31'b0, irq}, {31'b0, m_exc && (|m_stat)});
    chk("R9", "flush_pulse", {31'b0, flush_pulse}, {31'b0, m_pulse});
    chk(rd_tag(reg_addr), "rdata", reg_rdata, exp_rd(reg_addr));
  endtask

  task automatic step(logic wr, logic [11:0] a, logic [31:0] d,
                      logic fv = 1'b0, logic [2:0] fc = 3'b0, logic [31:0] fa = 32'h0);
    logic [2:0] keep, left, nc;
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d;
    flt_valid = fv; flt_cause = fc; flt_addr = fa;
    @(posedge clk);
    keep = (wr && a == 12'h384) ? d[2:0] : 3'b111;
    left = m_stat & keep;
    nc = fv ? fc : 3'b0;
    if ((|nc) && !(|left)) m_faddr = fa;
    m_stat = left | nc;
    m_pulse = wr && a == 12'h184 && d[4] && !m_fbit;
    if (wr && a == 12'h184) m_fbit = d[4];
    if (wr && a == 12'h388) m_en = d[0];
    if (wr && a == 12'h38C) m_base = d;
    if (wr && a == 12'h1AC) m_oob = d[28];
    if (wr && a == 12'h380) m_exc = d[0];
    #2;
    check_all();
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] offs [7];
    offs = '{12'h184, 12'h1AC, 12'h380, 12'h384, 12'h388, 12'h38C, 12'h000};
    void'($urandom(32'd1234));
    {m_en, m_oob, m_exc, m_fbit, m_pulse} = '0;
    m_base = '0; m_faddr = '0; m_stat = '0;
    repeat (3) @(posedge clk);
    // R1: reset state at each defined offset
    foreach (offs[i]) begin
      reg_addr = offs[i]; #1;
      chk("R1", "reset rdata", reg_rdata, 32'h0);
    end
    chk("R1", "reset outputs", {27'b0, xlat_en, oob_en, flush_pulse, irq, |tbl_base}, 32'h0);
    @(negedge clk); rst_n = 1'b1;

    // R2 R3 R4 R5: enable sequence, enable read first
    step(0, 12'h388, 0);
    step(1, 12'h38C, 32'hDEAD_BEEF);
    step(1, 12'h1AC, 32'hFFFF_FFFF);
    step(1, 12'h380, 32'h1);
    step(1, 12'h388, 32'hFFFF_FFFF);
    step(0, 12'h1AC, 0);
    step(1, 12'h388, 32'h0);            // R2 disable
    step(1, 12'h388, 32'h1);

    // R9: flush toggle, repeated 1 gives no pulse
    step(1, 12'h184, 32'h10);
    step(0, 12'h184, 0);
    step(1, 12'h184, 32'h10);
    step(1, 12'h184, 32'h0);
    step(1, 12'h184, 32'hFFFF_FFEF);    // bit 4 clear, no pulse

    // R7 R8: first fault kept, second fault ignored for address
    step(0, 12'h380, 0, 1, 3'b001, 32'h1111_0000);
    step(0, 12'h380, 0, 1, 3'b100, 32'h2222_0000);
    step(0, 12'h384, 0);
    step(1, 12'h384, 32'h4);            // R6 partial clear keeps bit 2
    step(1, 12'h384, 32'h0);            // R6 full clear
    // R11: clear and fault in same cycle
    step(0, 12'h384, 0, 1, 3'b010, 32'h3333_0000);
    step(1, 12'h384, 32'h0, 1, 3'b001, 32'h4444_0000);
    step(0, 12'h380, 0);
    step(1, 12'h384, 32'h1, 1, 3'b100, 32'h5555_0000);  // bit0 still pending
    step(0, 12'h380, 0);
    // R8: exception disabled gates irq
    step(1, 12'h380, 32'h0);
    step(1, 12'h380, 32'h1);
    step(1, 12'h384, 32'h0);
    // R5: fault with zero cause is ignored
    step(0, 12'h380, 0, 1, 3'b000, 32'h6666_0000);
    // R10: undefined offsets
    step(1, 12'h38A, 32'hFFFF_FFFF);
    step(1, 12'h000, 32'hFFFF_FFFF);
    step(0, 12'h390, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ($urandom % 5 == 0) ? 12'($urandom & 12'hFFF) : offs[$urandom % 6];
      d = $urandom;
      if (a == 12'h384 && ($urandom % 2 == 0)) d = 32'h0;
      step(($urandom % 3) != 0, a, d, ($urandom % 4) == 0, 3'($urandom), $urandom);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule